// File: doc/BRIEF.md
# Daisy-Chain Management Bus Transmit Arbiter

This block connects a network controller to a shared hub-management serial bus as one more node in a chain of nodes that pass transmit permission downward. Permission arrives from the node above. It is passed on to the node below only when this node does not itself want to send. The block never stops the local controller from transmitting. A node that sends without permission instead announces a collision on the bus, so that every node on the chain backs off.

The block also announces activity when it sends with permission. It enables the bus transmit driver only when the controller is in external-encoder mode. It returns a collision indication to the controller, and it divides the oscillator by two to make the transmit clock. Every line that faces the bus is active-low at the ports, to suit inverting bus transceivers. Every output is registered once on the oscillator clock. A decision made from the inputs at one rising edge therefore appears at the outputs right after that edge.

Top module: `mgmt_tx_arbiter`

## Requirements
- R1: While `rst_n` is low, `grant_out_n`, `busy_n` and `clash_n` are 1, and `ctl_coll`, `drv_en` and `txclk_oe` are 0.
- R2: After each rising edge, `grant_out_n` is 0 exactly when, at that edge, `grant_in_n` was 0 and `ctl_tx_en` was 0. Otherwise it is 1.
- R3: After each rising edge, `busy_n` is 0 exactly when, at that edge, `ctl_tx_en` was 1 and `grant_in_n` was 0.
- R4: After each rising edge, `clash_n` is 0 exactly when, at that edge, `ctl_tx_en` was 1 and `grant_in_n` was 1. The local transmit enable is never masked.
- R5: After each rising edge, `ctl_coll` is 1 exactly when, at that edge, either `rx_coll_n` was 0, or `bus_coll_n` was 0 while `ctl_tx_en` was 1.
- R6: After each rising edge, `drv_en` is 1 exactly when, at that edge, `ctl_tx_en` was 1, `grant_in_n` was 0 and `ext_enc_mode` was 1.
- R7: `ctl_txclk` toggles on every rising edge of `clk` after reset, giving the oscillator divided by two.
- R8: `txclk_oe` follows `ext_enc_mode` with one register of delay. `txclk_bus` carries `ctl_txclk` while `txclk_oe` is 1, and is high-impedance otherwise.
- R9: On a chain of three nodes whose upper input is granted, with `bus_coll_n` formed as the AND of all `clash_n` lines, the following holds once the chain has settled. The uppermost requester drives `busy_n` low. Every lower requester drives `clash_n` low. While two or more nodes request, every requester sees `ctl_coll` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_enc_mode | input | 1 | Controller uses the external encoder (bus mode) |
| ctl_tx_en | input | 1 | Controller transmit enable, active high |
| grant_in_n | input | 1 | Permission from the node above, active low |
| bus_coll_n | input | 1 | Sensed bus collision line, active low |
| rx_coll_n | input | 1 | Receive collision from the network, active low |
| grant_out_n | output | 1 | Permission to the node below, active low |
| busy_n | output | 1 | Activity announce, active low |
| clash_n | output | 1 | Collision announce, active low |
| drv_en | output | 1 | Bus transmit driver enable, active high |
| ctl_coll | output | 1 | Collision indication to the controller |
| ctl_txclk | output | 1 | Divided transmit clock to the controller |
| txclk_oe | output | 1 | Output enable for the bus transmit clock |
| txclk_bus | output | 1 | Transmit clock onto the bus, high-impedance when not enabled |

## Verification
The embedded properties check, on every cycle after reset, that each announce, grant and driver output and the controller collision follow from the inputs of the previous edge. They also check that the driver enable never appears without activity, and that the bus clock enable matches the encoder mode. The properties cannot show that the chain of nodes, once wired together, settles to a single active holder with collision announcements from the lower requesters. That outcome, together with the full input sweep and the clock division, is shown only by the bench scenarios.

// File: rtl/mgmt_arb_pkg.sv
package mgmt_arb_pkg;

    typedef struct packed {
        logic grant;
        logic busy;
        logic clash;
        logic drv;
        logic coll;
        logic clk_oe;
    } arb_state_t;

    localparam arb_state_t ARB_IDLE = '{
        grant:  1'b0,
        busy:   1'b0,
        clash:  1'b0,
        drv:    1'b0,
        coll:   1'b0,
        clk_oe: 1'b0
    };

endpackage

// File: rtl/mgmt_perm_logic.sv
module mgmt_perm_logic (
    input  logic want,
    input  logic perm,
    input  logic ext_mode,
    output logic grant_nx,
    output logic busy_nx,
    output logic clash_nx,
    output logic drv_nx
);
    always_comb begin
        grant_nx = perm & ~want;
        busy_nx  = want & perm;
        clash_nx = want & ~perm;
        drv_nx   = want & perm & ext_mode;
    end
endmodule

// File: rtl/mgmt_coll_merge.sv
module mgmt_coll_merge (
    input  logic want,
    input  logic bus_coll,
    input  logic rx_coll,
    output logic coll_nx
);
    always_comb begin
        coll_nx = (want & bus_coll) | rx_coll;
    end
endmodule

// File: rtl/mgmt_txclk_div.sv
module mgmt_txclk_div #(
    parameter int DIV_LOG2 = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic div_clk
);
    localparam int CW = (DIV_LOG2 < 1) ? 1 : DIV_LOG2;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign div_clk = cnt_q[CW-1];
endmodule

// File: rtl/mgmt_tx_arbiter.sv
module mgmt_tx_arbiter
    import mgmt_arb_pkg::*;
#(
    parameter int DIV_LOG2 = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_enc_mode,
    input  logic ctl_tx_en,
    input  logic grant_in_n,
    input  logic bus_coll_n,
    input  logic rx_coll_n,
    output logic grant_out_n,
    output logic busy_n,
    output logic clash_n,
    output logic drv_en,
    output logic ctl_coll,
    output logic ctl_txclk,
    output logic txclk_oe,
    output logic txclk_bus
);
    arb_state_t st_d, st_q;

    logic perm, bus_coll, rx_coll;
    logic grant_nx, busy_nx, clash_nx, drv_nx, coll_nx;
    logic div_clk;
    logic armed_q;

    assign perm     = ~grant_in_n;
    assign bus_coll = ~bus_coll_n;
    assign rx_coll  = ~rx_coll_n;

    mgmt_perm_logic u_perm (
        .want     (ctl_tx_en),
        .perm     (perm),
        .ext_mode (ext_enc_mode),
        .grant_nx (grant_nx),
        .busy_nx  (busy_nx),
        .clash_nx (clash_nx),
        .drv_nx   (drv_nx)
    );

    mgmt_coll_merge u_coll (
        .want     (ctl_tx_en),
        .bus_coll (bus_coll),
        .rx_coll  (rx_coll),
        .coll_nx  (coll_nx)
    );

    mgmt_txclk_div #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_clk (div_clk)
    );

    always_comb begin
        st_d        = st_q;
        st_d.grant  = grant_nx;
        st_d.busy   = busy_nx;
        st_d.clash  = clash_nx;
        st_d.drv    = drv_nx;
        st_d.coll   = coll_nx;
        st_d.clk_oe = ext_enc_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ARB_IDLE;
            armed_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            armed_q <= 1'b1;
        end
    end

    // Bus-facing announce lines are inverted for inverting transceivers
    assign grant_out_n = ~st_q.grant;
    assign busy_n      = ~st_q.busy;
    assign clash_n     = ~st_q.clash;
    assign drv_en      = st_q.drv;
    assign ctl_coll    = st_q.coll;
    assign ctl_txclk   = div_clk;
    assign txclk_oe    = st_q.clk_oe;
    assign txclk_bus   = st_q.clk_oe ? div_clk : 1'bz;

    a_r2_grant_only_idle_and_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !grant_out_n) |-> $past(!grant_in_n && !ctl_tx_en));

    a_r3_busy_needs_permission: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !busy_n) |-> $past(ctl_tx_en && !grant_in_n));

    a_r4_clash_on_unpermitted_send: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(ctl_tx_en && grant_in_n)) |-> !clash_n);

    a_r5_rx_collision_reaches_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(!rx_coll_n)) |-> ctl_coll);

    a_r6_driver_implies_activity: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (!busy_n && $past(ext_enc_mode)));

    a_r8_clock_enable_tracks_mode: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (txclk_oe == $past(ext_enc_mode)));

    a_r7_txclk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && DIV_LOG2 == 1) |-> (ctl_txclk != $past(ctl_txclk)));
endmodule

// File: tb/sim_mgmt_tx_arbiter.sv
`timescale 1ns/1ps
module sim_mgmt_tx_arbiter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic ext, txen, gin_n, bcol_n, rcol_n;
    logic gout_n, busy_n, clash_n, drv, coll, tclk, toe, tbus;

    mgmt_tx_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .ext_enc_mode(ext), .ctl_tx_en(txen),
        .grant_in_n(gin_n), .bus_coll_n(bcol_n), .rx_coll_n(rcol_n),
        .grant_out_n(gout_n), .busy_n(busy_n), .clash_n(clash_n),
        .drv_en(drv), .ctl_coll(coll), .ctl_txclk(tclk),
        .txclk_oe(toe), .txclk_bus(tbus)
    );

    // Chain of three nodes for R9
    logic [2:0] c_tx, c_gin_n, c_gout_n, c_busy_n, c_clash_n, c_drv, c_coll;
    logic [2:0] c_tclk, c_toe, c_tbus;
    logic chain_bcol_n;
    assign chain_bcol_n = &c_clash_n;
    assign c_gin_n[0] = 1'b0;
    assign c_gin_n[1] = c_gout_n[0];
    assign c_gin_n[2] = c_gout_n[1];

    for (genvar g = 0; g < 3; g++) begin : g_chain
        mgmt_tx_arbiter u_node (
            .clk(clk), .rst_n(rst_n), .ext_enc_mode(1'b1), .ctl_tx_en(c_tx[g]),
            .grant_in_n(c_gin_n[g]), .bus_coll_n(chain_bcol_n), .rx_coll_n(1'b1),
            .grant_out_n(c_gout_n[g]), .busy_n(c_busy_n[g]), .clash_n(c_clash_n[g]),
            .drv_en(c_drv[g]), .ctl_coll(c_coll[g]), .ctl_txclk(c_tclk[g]),
            .txclk_oe(c_toe[g]), .txclk_bus(c_tbus[g])
        );
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic prev;
        ext = 0; txen = 1; gin_n = 0; bcol_n = 0; rcol_n = 0; c_tx = 3'b111;
        repeat (3) @(negedge clk);
        // R1 reset state, with active inputs present
        chk("R1", {2'b0, gout_n, busy_n, clash_n, drv, coll, toe}, 8'b0011_1000);
        rst_n = 1'b1;

        // Sweep all 32 input combinations (R2..R6, R8)
        for (int i = 0; i < 32; i++) begin
            logic w, p, bc, rc, e;
            @(negedge clk);
            txen = i[0]; gin_n = i[1]; bcol_n = i[2]; rcol_n = i[3]; ext = i[4];
            w = i[0]; p = ~i[1]; bc = ~i[2]; rc = ~i[3]; e = i[4];
            @(negedge clk);
            chk("R2", {7'b0, gout_n},  {7'b0, ~(p & ~w)});
            chk("R3", {7'b0, busy_n},  {7'b0, ~(w & p)});
            chk("R4", {7'b0, clash_n}, {7'b0, ~(w & ~p)});
            chk("R5", {7'b0, coll},    {7'b0, (w & bc) | rc});
            chk("R6", {7'b0, drv},     {7'b0, w & p & e});
            chk("R8", {7'b0, toe},     {7'b0, e});
            if (e) chk("R8", {7'b0, tbus}, {7'b0, tclk});
        end

        // R7 divide by two
        prev = tclk;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R7", {7'b0, tclk}, {7'b0, ~prev});
            prev = tclk;
        end

        // R9 chain scenarios: {requests} -> expected busy/clash/coll
        c_tx = 3'b000; repeat (5) @(negedge clk);
        chk("R9", {5'b0, c_gout_n}, 8'h00);
        chk("R9", {5'b0, c_busy_n & c_clash_n}, 8'h07);

        c_tx = 3'b010; repeat (5) @(negedge clk);
        chk("R9", {5'b0, c_busy_n},  8'h05);
        chk("R9", {5'b0, c_clash_n}, 8'h07);
        chk("R9", {5'b0, c_coll},    8'h00);

        c_tx = 3'b110; repeat (5) @(negedge clk);
        chk("R9", {5'b0, c_busy_n},  8'h05);
        chk("R9", {5'b0, c_clash_n}, 8'h03);
        chk("R9", {5'b0, c_coll},    8'h06);

        c_tx = 3'b101; repeat (5) @(negedge clk);
        chk("R9", {5'b0, c_busy_n},  8'h06);
        chk("R9", {5'b0, c_clash_n}, 8'h03);
        chk("R9", {5'b0, c_coll},    8'h05);

        c_tx = 3'b111; repeat (5) @(negedge clk);
        chk("R9", {5'b0, c_busy_n},  8'h06);
        chk("R9", {5'b0, c_clash_n}, 8'h01);
        chk("R9", {5'b0, c_drv},     8'h01);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule